// File: doc/BRIEF.md
# Relocation and Range Guard

This block sits between an address-generating pipeline and memory. A program issues addresses relative to the start of its own region. The block adds a frame-aligned base to each relative address to form the absolute address. It then compares the result against a frame-aligned limit and either grants the access or flags a range fault.

Base and limit are each held as a frame number. A frame is a 16-word block, so each register carries only the upper bits of the address and the low bits are implicitly zero. A supervisor loads both registers through a small write port just before a program is started or resumed. Requests arrive with a valid strobe. Each verdict appears one cycle later, together with the absolute address.

A sticky fault flag remembers that at least one access was refused. The flag is cleared only by an explicit clear pulse.

Top module: `reloc_guard`

## Requirements
- R1: After a synchronous active-low reset, `rsp_valid`, `rsp_grant`, `rsp_fault` and `fault_sticky` are low, and the base and limit frames are both zero, so every access before the first limit load is refused.
- R2: A write with `cfg_we` high loads `cfg_data` into the base frame when `cfg_sel` is 0 and into the limit frame when `cfg_sel` is 1. The new value applies to requests from the next cycle on. A request in the same cycle as the write is judged with the previous value.
- R3: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high. While it is low, `rsp_grant` and `rsp_fault` are low.
- R4: `rsp_addr` equals the relative address plus the base frame shifted left by 4 bits, taken modulo 2^22.
- R5: When `rsp_valid` is high, exactly one of `rsp_grant` and `rsp_fault` is high. Grant means the absolute address is below the limit frame shifted left by 4 bits.
- R6: An absolute address equal to the shifted limit is refused. An address one below the shifted limit is granted.
- R7: A carry out of the 22-bit addition is refused, even when the truncated sum lies below the limit.
- R8: `fault_sticky` rises in the same cycle as `rsp_fault`. It then stays high until a cycle with `fault_clr` high and no new fault. A fault in the clearing cycle keeps the flag set.
- R9: Requests never alter the base or limit frames: the same relative address issued repeatedly gives the same absolute address and verdict.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Frame register write enable |
| cfg_sel | input | 1 | Target: 0 base frame, 1 limit frame |
| cfg_data | input | 18 | Frame number to write |
| req_valid | input | 1 | Relative address strobe |
| req_addr | input | 22 | Unsigned relative address |
| fault_clr | input | 1 | Clears the sticky fault flag |
| rsp_valid | output | 1 | Verdict valid, one cycle after the request |
| rsp_addr | output | 22 | Absolute address |
| rsp_grant | output | 1 | Access allowed |
| rsp_fault | output | 1 | Access refused, out of range |
| fault_sticky | output | 1 | At least one refusal since last clear |

## Verification
Two pairs of functions can coincide in a single cycle. A frame write can land on the same edge as a request. A sticky clear can meet a new fault. The bench drives a base write together with a request, and its scoreboard expects the old base to be used and the new base on the following request. It also pulses `fault_clr` once alongside a refused access, where the flag must stay set, and once alongside a granted access, where the flag must drop.

// File: rtl/reloc_pkg.sv
// Shared types for the relocation guard.
// Assumes: single clock domain, frames are power-of-two aligned blocks.
package reloc_pkg;

    // Which frame register a configuration write targets.
    typedef enum logic {
        SEL_BASE  = 1'b0,
        SEL_LIMIT = 1'b1
    } frame_sel_e;

    // Outcome of one range check.
    typedef struct packed {
        logic grant;
        logic fault;
    } verdict_t;

endpackage

// File: rtl/reloc_frames.sv
// Holds the base and limit frame numbers.
// Assumes: writes come from a supervisor between programs; one register per write.
module reloc_frames #(
    parameter int FRAME_W = 18
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  reloc_pkg::frame_sel_e sel,
    input  logic [FRAME_W-1:0]  wdata,
    output logic [FRAME_W-1:0]  base_o,
    output logic [FRAME_W-1:0]  limit_o
);
    localparam int NUM_REGS = 2;

    logic [FRAME_W-1:0] frame_q [NUM_REGS];

    for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_frame
        // Load one frame register when it is selected, clear on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                frame_q[gi] <= '0;
            end else if (we && (int'(sel) == gi)) begin
                frame_q[gi] <= wdata;
            end
        end
    end

    assign base_o  = frame_q[int'(reloc_pkg::SEL_BASE)];
    assign limit_o = frame_q[int'(reloc_pkg::SEL_LIMIT)];
endmodule

// File: rtl/reloc_calc.sv
// Forms the absolute address and judges it against the limit, combinationally.
// Assumes: relative address is unsigned; carry out of the sum counts as out of range.
module reloc_calc #(
    parameter int FRAME_W  = 18,
    parameter int BLK_BITS = 4
) (
    input  logic [FRAME_W+BLK_BITS-1:0] rel_i,
    input  logic [FRAME_W-1:0]          base_i,
    input  logic [FRAME_W-1:0]          limit_i,
    output logic [FRAME_W+BLK_BITS-1:0] abs_o,
    output reloc_pkg::verdict_t         verdict_o
);
    localparam int ADDR_W = FRAME_W + BLK_BITS;

    logic [ADDR_W:0]   sum_w;
    logic [ADDR_W-1:0] limit_addr;
    logic              out_of_range;

    // One add with a carry bit, one unsigned compare.
    always_comb begin
        sum_w        = {1'b0, rel_i} + {1'b0, base_i, {BLK_BITS{1'b0}}};
        limit_addr   = {limit_i, {BLK_BITS{1'b0}}};
        out_of_range = sum_w[ADDR_W] || (sum_w[ADDR_W-1:0] >= limit_addr);
        abs_o        = sum_w[ADDR_W-1:0];
        verdict_o.grant = !out_of_range;
        verdict_o.fault = out_of_range;
    end
endmodule

// File: rtl/reloc_result.sv
// Registers the verdict and absolute address; keeps the sticky fault flag.
// Assumes: clear loses to a fault arriving on the same edge.
module reloc_result #(
    parameter int ADDR_W = 22
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [ADDR_W-1:0]   abs_i,
    input  reloc_pkg::verdict_t verdict_i,
    input  logic                fault_clr,
    output logic                rsp_valid,
    output logic [ADDR_W-1:0]   rsp_addr,
    output logic                rsp_grant,
    output logic                rsp_fault,
    output logic                fault_sticky
);
    // Capture one verdict per request; outputs idle low between requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_addr  <= '0;
            rsp_grant <= 1'b0;
            rsp_fault <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            rsp_grant <= req_valid && verdict_i.grant;
            rsp_fault <= req_valid && verdict_i.fault;
            if (req_valid) begin
                rsp_addr <= abs_i;
            end
        end
    end

    // Sticky flag: set by any refusal, dropped only by an explicit clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_sticky <= 1'b0;
        end else begin
            fault_sticky <= (fault_sticky && !fault_clr) || (req_valid && verdict_i.fault);
        end
    end
endmodule

// File: rtl/reloc_guard.sv
// Top: relocates program-relative addresses and enforces a base/limit window.
// Assumes: frame registers are loaded before requests of the program they guard.
module reloc_guard #(
    parameter int FRAME_W  = 18,
    parameter int BLK_BITS = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_we,
    input  logic                        cfg_sel,
    input  logic [FRAME_W-1:0]          cfg_data,
    input  logic                        req_valid,
    input  logic [FRAME_W+BLK_BITS-1:0] req_addr,
    input  logic                        fault_clr,
    output logic                        rsp_valid,
    output logic [FRAME_W+BLK_BITS-1:0] rsp_addr,
    output logic                        rsp_grant,
    output logic                        rsp_fault,
    output logic                        fault_sticky
);
    localparam int ADDR_W = FRAME_W + BLK_BITS;

    logic [FRAME_W-1:0]  base_w;
    logic [FRAME_W-1:0]  limit_w;
    logic [ADDR_W-1:0]   abs_w;
    reloc_pkg::verdict_t verdict_w;
    reloc_pkg::frame_sel_e sel_w;

    assign sel_w = reloc_pkg::frame_sel_e'(cfg_sel);

    reloc_frames #(.FRAME_W(FRAME_W)) u_frames (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .sel     (sel_w),
        .wdata   (cfg_data),
        .base_o  (base_w),
        .limit_o (limit_w)
    );

    reloc_calc #(.FRAME_W(FRAME_W), .BLK_BITS(BLK_BITS)) u_calc (
        .rel_i     (req_addr),
        .base_i    (base_w),
        .limit_i   (limit_w),
        .abs_o     (abs_w),
        .verdict_o (verdict_w)
    );

    reloc_result #(.ADDR_W(ADDR_W)) u_result (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .abs_i        (abs_w),
        .verdict_i    (verdict_w),
        .fault_clr    (fault_clr),
        .rsp_valid    (rsp_valid),
        .rsp_addr     (rsp_addr),
        .rsp_grant    (rsp_grant),
        .rsp_fault    (rsp_fault),
        .fault_sticky (fault_sticky)
    );
endmodule

// File: rtl/reloc_guard_chk.sv
// Property checker for reloc_guard, attached by bind.
// Assumes: observes top ports plus the frame register outputs.
module reloc_guard_chk #(
    parameter int FRAME_W  = 18,
    parameter int BLK_BITS = 4
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        cfg_we,
    input logic                        cfg_sel,
    input logic [FRAME_W-1:0]          cfg_data,
    input logic                        req_valid,
    input logic [FRAME_W+BLK_BITS-1:0] req_addr,
    input logic                        fault_clr,
    input logic                        rsp_valid,
    input logic [FRAME_W+BLK_BITS-1:0] rsp_addr,
    input logic                        rsp_grant,
    input logic                        rsp_fault,
    input logic                        fault_sticky,
    input logic [FRAME_W-1:0]          base_w,
    input logic [FRAME_W-1:0]          limit_w
);
    localparam int ADDR_W = FRAME_W + BLK_BITS;

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (!rsp_valid && !rsp_grant && !rsp_fault && !fault_sticky
                    && base_w == '0 && limit_w == '0));

    // R2
    base_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_sel) |=> base_w == $past(cfg_data));

    // R2
    limit_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel) |=> limit_w == $past(cfg_data));

    // R3
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R3
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_grant && !rsp_fault));

    // R4
    abs_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_addr == ADDR_W'($past(req_addr) + {$past(base_w), {BLK_BITS{1'b0}}}));

    // R5
    one_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_grant ^ rsp_fault));

    // R5
    grant_below_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_grant |-> rsp_addr < {$past(limit_w), {BLK_BITS{1'b0}}});

    // R8
    sticky_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> fault_sticky);

    // R8
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_sticky && !fault_clr) |=> fault_sticky);

    // R9
    frames_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> ($stable(base_w) && $stable(limit_w)));
endmodule

bind reloc_guard reloc_guard_chk #(.FRAME_W(FRAME_W), .BLK_BITS(BLK_BITS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we       (cfg_we),
    .cfg_sel      (cfg_sel),
    .cfg_data     (cfg_data),
    .req_valid    (req_valid),
    .req_addr     (req_addr),
    .fault_clr    (fault_clr),
    .rsp_valid    (rsp_valid),
    .rsp_addr     (rsp_addr),
    .rsp_grant    (rsp_grant),
    .rsp_fault    (rsp_fault),
    .fault_sticky (fault_sticky),
    .base_w       (base_w),
    .limit_w      (limit_w)
);

// File: tb/reloc_guard_tb.sv
// Scoreboard bench for reloc_guard: driver pushes expectations, monitor pops.
module reloc_guard_tb;
    localparam int FW = 18;
    localparam int BB = 4;
    localparam int AW = FW + BB;

    typedef struct {
        logic [AW-1:0] addr;
        logic          grant;
        string         req;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic          cfg_sel = 1'b0;
    logic [FW-1:0] cfg_data = '0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          fault_clr = 1'b0;
    logic          rsp_valid;
    logic [AW-1:0] rsp_addr;
    logic          rsp_grant;
    logic          rsp_fault;
    logic          fault_sticky;

    int checks = 0;
    int fails  = 0;
    logic [FW-1:0] m_base  = '0;
    logic [FW-1:0] m_limit = '0;
    exp_t sb_q[$];
    bit   finished = 1'b0;

    reloc_guard u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_data(cfg_data), .req_valid(req_valid), .req_addr(req_addr),
        .fault_clr(fault_clr), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
        .rsp_grant(rsp_grant), .rsp_fault(rsp_fault), .fault_sticky(fault_sticky)
    );

    always #4ns clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [AW-1:0] act, input logic [AW-1:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    function automatic exp_t predict(input logic [AW-1:0] rel, input string req);
        exp_t e;
        logic [AW:0] s;
        s = {1'b0, rel} + {1'b0, m_base, 4'b0000};
        e.addr  = s[AW-1:0];
        e.grant = !s[AW] && (s[AW-1:0] < {m_limit, 4'b0000});
        e.req   = req;
        return e;
    endfunction

    // Driver: one request, optionally with a frame write on the same edge.
    task automatic issue(input logic [AW-1:0] rel, input string req,
                         input bit wr = 0, input bit sel = 0, input logic [FW-1:0] d = '0,
                         input bit clr = 0);
        req_valid = 1'b1;
        req_addr  = rel;
        cfg_we    = wr;
        cfg_sel   = sel;
        cfg_data  = d;
        fault_clr = clr;
        sb_q.push_back(predict(rel, req));
        @(negedge clk);
        req_valid = 1'b0;
        cfg_we    = 1'b0;
        fault_clr = 1'b0;
        if (wr) begin
            if (sel) m_limit = d; else m_base = d;
        end
    endtask

    task automatic write_frame(input bit sel, input logic [FW-1:0] d);
        cfg_we = 1'b1; cfg_sel = sel; cfg_data = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (sel) m_limit = d; else m_base = d;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Monitor: compare each verdict against the front of the scoreboard.
    initial begin
        forever begin
            @(posedge clk);
            #2ns;
            if (rst_n && (rsp_valid || sb_q.size() != 0)) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R3", "unexpected rsp_valid", AW'(rsp_valid), '0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(rsp_valid == 1'b1, "R3", "rsp_valid", AW'(rsp_valid), AW'(1));
                    check(rsp_addr == e.addr, {e.req, "/R4"}, "rsp_addr", rsp_addr, e.addr);
                    check(rsp_grant == e.grant && rsp_fault == !e.grant, {e.req, "/R5"},
                          "grant", AW'(rsp_grant), AW'(e.grant));
                end
            end
        end
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        #400us;
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: idle outputs after reset
        check(!rsp_valid && !rsp_grant && !rsp_fault && !fault_sticky, "R1", "reset outputs",
              AW'({rsp_valid, rsp_grant, rsp_fault, fault_sticky}), '0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: zero limit refuses everything
        issue(22'h000000, "R1");
        check(fault_sticky == 1'b1, "R8", "sticky after fault", AW'(fault_sticky), AW'(1));
        issue(22'h000005, "R8", 0, 0, '0, 1);   // R8: fault together with clear keeps flag
        check(fault_sticky == 1'b1, "R8", "sticky fault+clear", AW'(fault_sticky), AW'(1));

        // R2: window 0x1000..0x1FFF
        write_frame(1'b0, 18'h00100);
        write_frame(1'b1, 18'h00200);
        fault_clr = 1'b1;
        @(negedge clk);
        fault_clr = 1'b0;
        check(fault_sticky == 1'b0, "R8", "sticky cleared", AW'(fault_sticky), '0);
        issue(22'h000000, "R4");
        issue(22'h000123, "R4");
        issue(22'h000FFF, "R6");       // one below limit: grant
        check(fault_sticky == 1'b0, "R8", "no sticky on grant", AW'(fault_sticky), '0);
        issue(22'h001000, "R6");       // equal to limit: fault
        issue(22'h1FFFFF, "R5");
        // R9: repeated requests give identical results
        for (int i = 0; i < 3; i++) issue(22'h000ABC, "R9");

        // R8: clear with a granted access drops the flag
        issue(22'h000010, "R8", 0, 0, '0, 1);
        check(fault_sticky == 1'b0, "R8", "clear with grant", AW'(fault_sticky), '0);

        // R2: base write on the same edge as a request uses old base
        issue(22'h000040, "R2", 1, 0, 18'h00180);
        issue(22'h000040, "R2");
        // R2: limit write on the same edge as a request uses old limit
        issue(22'h000A00, "R2", 1, 1, 18'h00300);
        issue(22'h000A00, "R2");

        // R7: window at the very top, carry out must fault
        write_frame(1'b0, 18'h3FFF0);
        write_frame(1'b1, 18'h3FFFF);
        issue(22'h000100, "R7");
        issue(22'h0000EF, "R6");
        issue(22'h0000F0, "R6");
        issue(22'h3FFFFF, "R7");

        repeat (3) @(negedge clk);
        check(sb_q.size() == 0, "R3", "scoreboard drained", AW'(sb_q.size()), '0);
        check(!rsp_valid, "R3", "idle after traffic", AW'(rsp_valid), '0);
        finished = 1'b1;
        summary();
    end
endmodule